// File: doc/BRIEF.md
# Lane-Write Storage Port with Flow-Through Read

This block is the data side of a small synchronous storage port. A word is split into lanes, and each lane is a group of data bits plus one parity bit; with the default parameters a 36-bit word is made of four 9-bit lanes. A global write strobe writes a whole word. A gated set of per-lane selects writes only some lanes. Both are decoded into per-lane strobes that are registered together with the address and the chip-select condition at a rising clock edge. The write itself is committed at the following rising edge, using the data present on `wdata` at that edge.

Reads are flow-through. The word at the most recently captured address appears on `rdata` combinationally, in the same cycle as the capture and with no output register. `drive_en` tells the surrounding pad logic when to drive the bus. It needs the captured select to be true and the asynchronous `oe_n` to be low. It is forced low in any cycle that carries a pending write. A sleep input freezes every register and the storage, so contents are kept and no write or capture occurs while it is high.

Top module: `lanewr_port`

## Requirements
- R1: The port counts as selected at a rising edge only when `chip_en_n` is 0, `sel_hi` is 1 and `sel_lo_n` is 0. That captured select governs output drive and writes for the one following cycle only, so a deselect at the next edge drops `drive_en` right after that edge.
- R2: `glob_wr_n` = 0 at a selected edge marks all lanes for write. Every lane of the captured address takes the `wdata` present at the next rising edge, whatever `lane_wr_gate_n` and `lane_sel_n` are.
- R3: With `glob_wr_n` = 1 and `lane_wr_gate_n` = 0, each lane whose `lane_sel_n[l]` is 0 is written, and the other lanes of that word keep their contents.
- R4: With `glob_wr_n` = 1 and `lane_wr_gate_n` = 1, no lane is written, whatever `lane_sel_n` is.
- R5: Lane l covers data bits `wdata[8*l+7 : 8*l]` and the parity bit `wdata[32+l]`. Lane 2, for example, covers bits 23:16 and bit 34.
- R6: In any cycle that carries a pending write of one or more lanes, `drive_en` is 0.
- R7: In a selected, non-writing cycle with `oe_n` = 0, `drive_en` is 1 and `rdata` shows the stored word at the address captured at the most recent edge, in that same cycle.
- R8: `oe_n` acts without a clock. While it is 1, `drive_en` is 0. When it returns to 0 inside a selected, non-writing cycle, `drive_en` returns to 1 at once.
- R9: No lane is written after an edge at which the port was not selected, even if write controls were active at that edge.
- R10: While `sleep` is 1, rising edges change neither the captured address, select and write state nor the stored words. `drive_en` and `rdata` keep the values they had before the sleep.
- R11: After reset, `drive_en` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| sleep | input | 1 | High freezes all registers and storage |
| chip_en_n | input | 1 | Active-low enable, part of the select condition |
| sel_hi | input | 1 | Active-high select, part of the select condition |
| sel_lo_n | input | 1 | Active-low select, part of the select condition |
| addr | input | 4 | Word address captured at the clock edge |
| glob_wr_n | input | 1 | Active-low whole-word write |
| lane_wr_gate_n | input | 1 | Active-low gate that passes the per-lane selects |
| lane_sel_n | input | 4 | Active-low per-lane write selects |
| wdata | input | 36 | Write data, taken at the edge that commits a write |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Flow-through read data |
| drive_en | output | 1 | High when the data bus should be driven |

## Verification
Select, address and write strobes are taken at an edge and govern the next cycle. The bench therefore updates its reference model right after each rising edge and compares `drive_en` and `rdata` 2 ns later, inside that same cycle. A write's data is due at the edge after its capture, so the model commits the stored word only when it processes that later edge. Readbacks come one capture edge after the committing edge. `oe_n` is checked 1 ns after each change with no edge in between, which shows that its effect needs no clock.

// File: rtl/lanewr_pkg.sv
package lanewr_pkg;

   typedef enum logic [1:0] {
      WK_NONE   = 2'd0,
      WK_GLOBAL = 2'd1,
      WK_LANES  = 2'd2
   } wr_kind_e;

   function automatic logic chip_selected(input logic ce_n,
                                          input logic s_hi,
                                          input logic s_lo_n);
      return !ce_n && s_hi && !s_lo_n;
   endfunction

endpackage

// File: rtl/lanewr_decode.sv
module lanewr_decode
   import lanewr_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             glob_wr_n,
   input  logic             gate_n,
   input  logic [LANES-1:0] sel_n,
   output logic [LANES-1:0] strb,
   output wr_kind_e         kind
);

   // whole-word write wins; lane selects only pass when the gate is open
   always_comb begin
      if (!glob_wr_n) begin
         strb = '1;
         kind = WK_GLOBAL;
      end else if (!gate_n && (~sel_n != '0)) begin
         strb = ~sel_n;
         kind = WK_LANES;
      end else begin
         strb = '0;
         kind = WK_NONE;
      end
   end

endmodule

// File: rtl/lanewr_ctrl.sv
module lanewr_ctrl #(
   parameter int unsigned LANES  = 4,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              sel_now,
   input  logic [LANES-1:0]  strb,
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_q,
   output logic [LANES-1:0]  wr_q,
   output logic [ADDR_W-1:0] addr_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         wr_q   <= '0;
         addr_q <= '0;
      end else if (!hold) begin
         sel_q  <= sel_now;
         wr_q   <= sel_now ? strb : '0;
         addr_q <= addr;
      end
   end

   // R9: a pending write only exists in a selected cycle
   a_r9_no_write_unselected : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> (wr_q == '0));

   // R10: sleep freezes the captured state
   a_r10_sleep_holds : assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(sel_q) && $stable(wr_q) && $stable(addr_q)));

endmodule

// File: rtl/lanewr_store.sv
module lanewr_store #(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_BITS = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                           clk,
   input  logic                           wr_ok,
   input  logic [LANES-1:0]               lane_we,
   input  logic [ADDR_W-1:0]              waddr,
   input  logic [LANES*(LANE_BITS+1)-1:0] wdata,
   output logic [LANES*(LANE_BITS+1)-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned DBITS = LANES * LANE_BITS;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_BITS:0] mem [DEPTH];
      logic [LANE_BITS:0] rd_lane;

      always_ff @(posedge clk) begin
         if (wr_ok && lane_we[l])
            mem[waddr] <= {wdata[DBITS+l], wdata[l*LANE_BITS +: LANE_BITS]};
      end

      assign rd_lane                          = mem[waddr];
      assign rdata[l*LANE_BITS +: LANE_BITS]  = rd_lane[LANE_BITS-1:0];
      assign rdata[DBITS+l]                   = rd_lane[LANE_BITS];
   end

endmodule

// File: rtl/lanewr_port.sv
module lanewr_port
   import lanewr_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_BITS = 8,
   parameter int unsigned ADDR_W    = 4,
   localparam int unsigned W        = LANES * (LANE_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              chip_en_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              glob_wr_n,
   input  logic              lane_wr_gate_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic [W-1:0]      wdata,
   input  logic              oe_n,
   output logic [W-1:0]      rdata,
   output logic              drive_en
);

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("lanewr_port: LANES out of range");
   end
   if (LANE_BITS < 1) begin : g_bad_bits
      $error("lanewr_port: LANE_BITS must be positive");
   end
   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("lanewr_port: ADDR_W out of range");
   end

   logic              sel_now;
   logic [LANES-1:0]  strb;
   wr_kind_e          kind;
   logic              sel_q;
   logic [LANES-1:0]  wr_q;
   logic [ADDR_W-1:0] addr_q;

   assign sel_now = chip_selected(chip_en_n, sel_hi, sel_lo_n);

   lanewr_decode #(.LANES(LANES)) i_decode (
      .glob_wr_n (glob_wr_n),
      .gate_n    (lane_wr_gate_n),
      .sel_n     (lane_sel_n),
      .strb      (strb),
      .kind      (kind)
   );

   lanewr_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (sleep),
      .sel_now (sel_now),
      .strb    (strb),
      .addr    (addr),
      .sel_q   (sel_q),
      .wr_q    (wr_q),
      .addr_q  (addr_q)
   );

   lanewr_store #(.LANES(LANES), .LANE_BITS(LANE_BITS), .ADDR_W(ADDR_W)) i_store (
      .clk     (clk),
      .wr_ok   (sel_q && !sleep),
      .lane_we (wr_q),
      .waddr   (addr_q),
      .wdata   (wdata),
      .rdata   (rdata)
   );

   // flow-through drive qualifier, no register after the array
   assign drive_en = sel_q && !oe_n && (wr_q == '0);

   // R2: global write marks every lane
   a_r2_global_all : assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && sel_now && kind == WK_GLOBAL) |=> (wr_q == '1));

   // R4: closed gate without global write marks nothing
   a_r4_gate_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && glob_wr_n && lane_wr_gate_n) |=> (wr_q == '0));

   // R6: pending write keeps the bus undriven
   a_r6_write_off : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_q != '0) |-> !drive_en);

   // R1: deselected cycle never drives
   a_r1_desel_off : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_q |-> !drive_en);

   // R8: output enable high never drives
   a_r8_oe_off : assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_en);

endmodule

// File: tb/test_lanewr_port.sv
module test_lanewr_port;

   localparam int W = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic          chip_en_n = 1'b1;
   logic          sel_hi = 1'b1;
   logic          sel_lo_n = 1'b0;
   logic [3:0]    addr = '0;
   logic          glob_wr_n = 1'b1;
   logic          lane_wr_gate_n = 1'b1;
   logic [3:0]    lane_sel_n = 4'hF;
   logic [W-1:0]  wdata = '0;
   logic          oe_n = 1'b0;
   logic [W-1:0]  rdata;
   logic          drive_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [W-1:0] m_mem [16];
   logic         m_sel = 1'b0;
   logic [3:0]   m_wr = '0;
   logic [3:0]   m_addr = '0;

   always #5 clk = ~clk;

   lanewr_port i_lanewr_port (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .chip_en_n(chip_en_n),
      .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .addr(addr), .glob_wr_n(glob_wr_n),
      .lane_wr_gate_n(lane_wr_gate_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
      .oe_n(oe_n), .rdata(rdata), .drive_en(drive_en)
   );

   // R5 lane layout: data bits 8l..8l+7 and parity bit 32+l
   function automatic logic [W-1:0] lane_mask(input int l);
      logic [W-1:0] m = '0;
      m[l*8 +: 8] = 8'hFF;
      m[32+l] = 1'b1;
      return m;
   endfunction

   function automatic logic [3:0] lanes_of(input logic gw_n, input logic gate_n,
                                           input logic [3:0] sel_n);
      if (!gw_n) return 4'hF;
      if (!gate_n) return ~sel_n;
      return 4'h0;
   endfunction

   function automatic logic [W-1:0] pat(input int a);
      return {a[3:0], 32'hA5C3_0000 | 32'(a * 32'h0101)};
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_outputs(input string tag);
      logic exp_drive;
      string t;
      exp_drive = m_sel && !oe_n && (m_wr == 4'h0);
      t = tag;
      if (t == "") t = (m_wr != 0) ? "R6" : (!m_sel ? "R1" : (oe_n ? "R8" : "R7"));
      check(t, W'(drive_en), W'(exp_drive));
      if (exp_drive) check(t, rdata, m_mem[m_addr]);
   endtask

   task automatic cycle(input string tag);
      @(posedge clk);
      if (!sleep) begin
         if (m_sel)
            for (int l = 0; l < 4; l++)
               if (m_wr[l]) m_mem[m_addr] = (m_mem[m_addr] & ~lane_mask(l)) | (wdata & lane_mask(l));
         m_sel  = !chip_en_n && sel_hi && !sel_lo_n;
         m_wr   = m_sel ? lanes_of(glob_wr_n, lane_wr_gate_n, lane_sel_n) : 4'h0;
         m_addr = addr;
      end
      #2;
      check_outputs(tag);
   endtask

   task automatic set(input logic ce_n, input logic s_hi, input logic s_lo_n,
                      input logic [3:0] a, input logic gw_n, input logic gate_n,
                      input logic [3:0] sel_n, input logic [W-1:0] d);
      chip_en_n = ce_n; sel_hi = s_hi; sel_lo_n = s_lo_n; addr = a;
      glob_wr_n = gw_n; lane_wr_gate_n = gate_n; lane_sel_n = sel_n; wdata = d;
   endtask

   task automatic write_word(input logic [3:0] a, input logic gw_n, input logic gate_n,
                             input logic [3:0] sel_n, input logic [W-1:0] d, input string tag);
      set(1'b0, 1'b1, 1'b0, a, gw_n, gate_n, sel_n, d);
      cycle("R6");
      set(1'b1, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, d);
      cycle(tag);
   endtask

   task automatic read_word(input logic [3:0] a, input string tag);
      set(1'b0, 1'b1, 1'b0, a, 1'b1, 1'b1, 4'hF, '0);
      cycle(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      check("R11", W'(drive_en), W'(1'b0));

      // fill every word through the global write path
      for (int a = 0; a < 16; a++) write_word(4'(a), 1'b0, 1'b0, 4'h0, pat(a), "R2");
      for (int a = 0; a < 16; a++) read_word(4'(a), "R2");

      // R3: lanes 0 and 2 only
      write_word(4'd3, 1'b1, 1'b0, 4'b1010, 36'hF_FFFF_FFFF, "R3");
      read_word(4'd3, "R3");
      check("R3", rdata, (pat(3) & ~(lane_mask(0) | lane_mask(2))) | lane_mask(0) | lane_mask(2));

      // R5: lane 2 alone over a zero word
      write_word(4'd9, 1'b0, 1'b1, 4'hF, '0, "R5");
      write_word(4'd9, 1'b1, 1'b0, 4'b1011, 36'hF_FFFF_FFFF, "R5");
      read_word(4'd9, "R5");
      check("R5", rdata, 36'h4_00FF_0000);

      // R4: gate closed, selects active
      write_word(4'd4, 1'b1, 1'b1, 4'h0, 36'h0, "R4");
      read_word(4'd4, "R4");
      check("R4", rdata, pat(4));

      // R9: each select leg false in turn
      set(1'b1, 1'b1, 1'b0, 4'd5, 1'b0, 1'b0, 4'h0, 36'h0); cycle("R9");
      check("R9", W'(drive_en), W'(1'b0));
      cycle("R9");
      set(1'b0, 1'b0, 1'b0, 4'd5, 1'b0, 1'b0, 4'h0, 36'h0); cycle("R9"); cycle("R9");
      set(1'b0, 1'b1, 1'b1, 4'd5, 1'b0, 1'b0, 4'h0, 36'h0); cycle("R9"); cycle("R9");
      read_word(4'd5, "R9");
      check("R9", rdata, pat(5));

      // R1: single-cycle deselect
      read_word(4'd2, "R7");
      check("R7", rdata, pat(2));
      set(1'b1, 1'b1, 1'b0, 4'd2, 1'b1, 1'b1, 4'hF, '0); cycle("R1");
      check("R1", W'(drive_en), W'(1'b0));

      // R8: asynchronous output enable
      read_word(4'd6, "R7");
      oe_n = 1'b1; #1;
      check("R8", W'(drive_en), W'(1'b0));
      oe_n = 1'b0; #1;
      check("R8", W'(drive_en), W'(1'b1));
      check("R8", rdata, pat(6));

      // R10: sleep freezes capture and writes
      read_word(4'd6, "R7");
      sleep = 1'b1;
      set(1'b0, 1'b1, 1'b0, 4'd7, 1'b0, 1'b0, 4'h0, 36'h0);
      cycle("R10");
      check("R10", rdata, pat(6));
      cycle("R10");
      check("R10", W'(drive_en), W'(1'b1));
      sleep = 1'b0;
      read_word(4'd7, "R10");
      check("R10", rdata, pat(7));

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         set(($urandom % 5) == 0, ($urandom % 10) != 0, ($urandom % 10) == 0,
             4'($urandom), ($urandom % 4) != 0, ($urandom % 2) == 0,
             4'($urandom), {4'($urandom), $urandom});
         oe_n  = ($urandom % 6) == 0;
         sleep = ($urandom % 12) == 0;
         cycle("");
      end
      sleep = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule